// File: doc/BRIEF.md
# Double-Banked Coefficient Register File

This block stores the tap coefficients for a chain of three seven-tap multiply-accumulate arrays. It keeps two complete banks. Each bank holds one 8-bit coefficient per tap per array. At any moment one bank feeds the arrays, and a host fills the other bank through a byte-wide read/write port with full address decode. Every coefficient of both banks is exported. The coefficients of the active bank are also given as 9-bit values, widened to signed or unsigned form by a mode input.

The active bank is chosen by a bank-select input. Under a continuous swap mode it is chosen instead by a one-cycle end-of-frame strobe that flips the active bank. A small state machine holds the choice. Its four states are FIXED0 and FIXED1, where bank 0 or bank 1 is active and follows the select input, and ALT0 and ALT1, the same two banks under continuous swapping. Its transitions are:

- select follow, FIXED↔FIXED on the select input while swap mode is off.
- swap entry, FIXED0→ALT0 and FIXED1→ALT1, keeping the bank.
- frame swap, ALT0↔ALT1 on a strobe.
- swap hold, ALTn→ALTn with no strobe.
- swap exit, ALTn→FIXED given by the select input when swap mode drops.

A host write that lands in the active bank is still stored, but it sets a sticky error flag.

Top module: `coef_regfile`

## Requirements
- R1: After reset every stored coefficient is 0, active_bank_o is 0, wr_err_o is 0 and host_rdata_o is 0.
- R2: A coefficient's byte address is bank×0x40 + group×0x10 + tap, with tap 0..6. Group 0 serves array 2, group 1 serves array 1, and group 2 serves array 0. Tap 0 is the tap nearest the array output. A write appears in coef_bank_o bits [((bank×3+array)×7+tap)×8 +: 8] after the clock edge that takes it.
- R3: A read strobe at a defined address returns, on host_rdata_o after that clock edge, the byte held before the edge. host_rdata_o holds its value until the next read.
- R4: A read of an undefined address returns 0. An address is undefined if it is 0x080 or higher, if its group field [5:4] is 3, or if its tap field [3:0] is 7 or more.
- R5: A write to an undefined address changes no stored coefficient.
- R6: While swap_mode_i is 0, active_bank_o takes the value of bank_sel_i one clock after it is sampled.
- R7: When swap_mode_i rises, the active bank is kept. While swap_mode_i stays 1, each cycle with swap_strobe_i high toggles active_bank_o at the next edge, and other cycles keep it. swap_strobe_i has no effect while swap_mode_i is 0.
- R8: When swap_mode_i falls, active_bank_o returns to following bank_sel_i at the next edge.
- R9: act_coef_o bits [(array×7+tap)×9 +: 9] hold the active bank's coefficient. It is sign-extended when unsigned_mode_i is 0 and zero-extended when it is 1.
- R10: A write to a defined address in the active bank is stored and sets wr_err_o, which stays 1 until reset. Writes to the inactive bank leave wr_err_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr_i | input | 9 | Host byte address |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Registered host read byte |
| bank_sel_i | input | 1 | Bank select when swap mode is off |
| swap_mode_i | input | 1 | Continuous swap mode |
| swap_strobe_i | input | 1 | End-of-frame swap strobe |
| unsigned_mode_i | input | 1 | 1: coefficients unsigned, 0: signed |
| coef_bank_o | output | 336 | All coefficients of both banks |
| act_coef_o | output | 189 | Active-bank coefficients, 9 bits each |
| active_bank_o | output | 1 | Bank currently feeding the arrays |
| wr_err_o | output | 1 | Sticky flag for a write to the active bank |

## Verification
The properties assume that host_addr_i, the strobes and the mode inputs are stable across each clock edge. They also assume that swap_strobe_i is a plain level sampled once per edge, with no pairing between strobe pulses. The bench drives every input in the falling half of the clock, so each input holds one value per rising edge. It raises and lowers swap_mode_i freely, so the entry and exit arcs are taken many times. Addresses are drawn mostly from the defined map and sometimes from the whole 9-bit space, so undefined reads and writes reach the block.

// File: rtl/coef_pkg.sv
package coef_pkg;
    // Ping-pong storage: always two banks.
    localparam int NUM_BANKS = 2;
    localparam int BANK_IW   = 1;

    // Bank selection states.
    typedef enum logic [1:0] {
        ST_FIXED0 = 2'd0,
        ST_FIXED1 = 2'd1,
        ST_ALT0   = 2'd2,
        ST_ALT1   = 2'd3
    } bank_state_e;
endpackage

// File: rtl/coef_addr_dec.sv
module coef_addr_dec #(
    parameter int ADDR_W       = 9,
    parameter int NUM_ARRAYS   = 3,
    parameter int NUM_TAPS     = 7,
    parameter int BANK_STRIDE  = 64,
    parameter int GROUP_STRIDE = 16
) (
    input  logic [ADDR_W-1:0]                  addr_i,
    output logic                               valid_o,
    output logic [coef_pkg::BANK_IW-1:0]       bank_o,
    output logic [$clog2(NUM_ARRAYS)-1:0]      array_o,
    output logic [$clog2(NUM_TAPS)-1:0]        tap_o
);
    localparam int BANK_SH = $clog2(BANK_STRIDE);
    localparam int GRP_SH  = $clog2(GROUP_STRIDE);
    localparam int ARR_IW  = $clog2(NUM_ARRAYS);
    localparam int TAP_IW  = $clog2(NUM_TAPS);

    logic [ADDR_W-BANK_SH-1:0] bank_f;
    logic [BANK_SH-GRP_SH-1:0] grp_f;
    logic [GRP_SH-1:0]         tap_f;

    assign bank_f = addr_i[ADDR_W-1:BANK_SH];
    assign grp_f  = addr_i[BANK_SH-1:GRP_SH];
    assign tap_f  = addr_i[GRP_SH-1:0];

    always_comb begin
        valid_o = (int'(bank_f) < coef_pkg::NUM_BANKS) &&
                  (int'(grp_f)  < NUM_ARRAYS) &&
                  (int'(tap_f)  < NUM_TAPS);
        bank_o  = bank_f[coef_pkg::BANK_IW-1:0];
        // Lowest group serves the last array of the chain.
        array_o = ARR_IW'(NUM_ARRAYS - 1) - grp_f[ARR_IW-1:0];
        tap_o   = tap_f[TAP_IW-1:0];
    end
endmodule

// File: rtl/coef_bank_ctrl.sv
module coef_bank_ctrl
    import coef_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bank_sel_i,
    input  logic               swap_mode_i,
    input  logic               swap_strobe_i,
    output logic [BANK_IW-1:0] active_bank_o
);
    bank_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FIXED0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FIXED0, ST_FIXED1: begin
                if (swap_mode_i)     state_d = (state_q == ST_FIXED1) ? ST_ALT1 : ST_ALT0;
                else if (bank_sel_i) state_d = ST_FIXED1;
                else                 state_d = ST_FIXED0;
            end
            ST_ALT0: begin
                if (!swap_mode_i)       state_d = bank_sel_i ? ST_FIXED1 : ST_FIXED0;
                else if (swap_strobe_i) state_d = ST_ALT1;
                else                    state_d = ST_ALT0;
            end
            ST_ALT1: begin
                if (!swap_mode_i)       state_d = bank_sel_i ? ST_FIXED1 : ST_FIXED0;
                else if (swap_strobe_i) state_d = ST_ALT0;
                else                    state_d = ST_ALT1;
            end
            default: state_d = ST_FIXED0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_FIXED1, ST_ALT1: active_bank_o = 1'b1;
            default:            active_bank_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/coef_store.sv
module coef_store #(
    parameter int NUM_ARRAYS = 3,
    parameter int NUM_TAPS   = 7,
    parameter int COEF_W     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en_i,
    input  logic                                  addr_ok_i,
    input  logic [coef_pkg::BANK_IW-1:0]          bank_i,
    input  logic [$clog2(NUM_ARRAYS)-1:0]         array_i,
    input  logic [$clog2(NUM_TAPS)-1:0]           tap_i,
    input  logic [COEF_W-1:0]                     wdata_i,
    output logic [COEF_W-1:0]                     rdata_o,
    output logic [coef_pkg::NUM_BANKS*NUM_ARRAYS*NUM_TAPS*COEF_W-1:0] flat_o
);
    localparam int NB = coef_pkg::NUM_BANKS;

    logic [COEF_W-1:0] mem_q [NB][NUM_ARRAYS][NUM_TAPS];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        for (genvar a = 0; a < NUM_ARRAYS; a++) begin : g_arr
            for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
                logic hit;
                assign hit = wr_en_i && (int'(bank_i) == b) &&
                             (int'(array_i) == a) && (int'(tap_i) == t);
                always_ff @(posedge clk) begin
                    if (!rst_n)   mem_q[b][a][t] <= '0;
                    else if (hit) mem_q[b][a][t] <= wdata_i;
                end
                assign flat_o[((b*NUM_ARRAYS+a)*NUM_TAPS+t)*COEF_W +: COEF_W] = mem_q[b][a][t];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < NUM_ARRAYS; a++)
                for (int t = 0; t < NUM_TAPS; t++)
                    if (addr_ok_i && int'(bank_i) == b && int'(array_i) == a && int'(tap_i) == t)
                        rdata_o = mem_q[b][a][t];
    end
endmodule

// File: rtl/coef_active_sel.sv
module coef_active_sel #(
    parameter int NUM_ARRAYS = 3,
    parameter int NUM_TAPS   = 7,
    parameter int COEF_W     = 8
) (
    input  logic [coef_pkg::NUM_BANKS*NUM_ARRAYS*NUM_TAPS*COEF_W-1:0] flat_i,
    input  logic [coef_pkg::BANK_IW-1:0]                              bank_i,
    input  logic                                                      unsigned_i,
    output logic [NUM_ARRAYS*NUM_TAPS*(COEF_W+1)-1:0]                 act_o
);
    localparam int EXT_W = COEF_W + 1;

    for (genvar a = 0; a < NUM_ARRAYS; a++) begin : g_arr
        for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
            logic [COEF_W-1:0] pick;
            always_comb begin
                pick = '0;
                for (int b = 0; b < coef_pkg::NUM_BANKS; b++)
                    if (int'(bank_i) == b)
                        pick = flat_i[((b*NUM_ARRAYS+a)*NUM_TAPS+t)*COEF_W +: COEF_W];
            end
            assign act_o[(a*NUM_TAPS+t)*EXT_W +: EXT_W] =
                unsigned_i ? {1'b0, pick} : {pick[COEF_W-1], pick};
        end
    end
endmodule

// File: rtl/coef_regfile.sv
module coef_regfile #(
    parameter int ADDR_W       = 9,
    parameter int NUM_ARRAYS   = 3,
    parameter int NUM_TAPS     = 7,
    parameter int COEF_W       = 8,
    parameter int BANK_STRIDE  = 64,
    parameter int GROUP_STRIDE = 16
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic [ADDR_W-1:0]                              host_addr_i,
    input  logic                                           host_wr_i,
    input  logic                                           host_rd_i,
    input  logic [COEF_W-1:0]                              host_wdata_i,
    output logic [COEF_W-1:0]                              host_rdata_o,
    input  logic                                           bank_sel_i,
    input  logic                                           swap_mode_i,
    input  logic                                           swap_strobe_i,
    input  logic                                           unsigned_mode_i,
    output logic [2*NUM_ARRAYS*NUM_TAPS*COEF_W-1:0]        coef_bank_o,
    output logic [NUM_ARRAYS*NUM_TAPS*(COEF_W+1)-1:0]      act_coef_o,
    output logic                                           active_bank_o,
    output logic                                           wr_err_o
);
    localparam int ARR_IW = $clog2(NUM_ARRAYS);
    localparam int TAP_IW = $clog2(NUM_TAPS);

    logic                          dec_ok;
    logic [coef_pkg::BANK_IW-1:0]  dec_bank;
    logic [ARR_IW-1:0]             dec_arr;
    logic [TAP_IW-1:0]             dec_tap;
    logic [COEF_W-1:0]             store_rd;
    logic [coef_pkg::BANK_IW-1:0]  act_bank;
    logic [COEF_W-1:0]             rdata_q;
    logic                          err_q;

    coef_addr_dec #(
        .ADDR_W(ADDR_W), .NUM_ARRAYS(NUM_ARRAYS), .NUM_TAPS(NUM_TAPS),
        .BANK_STRIDE(BANK_STRIDE), .GROUP_STRIDE(GROUP_STRIDE)
    ) dec_i (
        .addr_i(host_addr_i), .valid_o(dec_ok), .bank_o(dec_bank),
        .array_o(dec_arr), .tap_o(dec_tap)
    );

    coef_bank_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .bank_sel_i(bank_sel_i),
        .swap_mode_i(swap_mode_i), .swap_strobe_i(swap_strobe_i),
        .active_bank_o(act_bank)
    );

    coef_store #(
        .NUM_ARRAYS(NUM_ARRAYS), .NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(host_wr_i && dec_ok),
        .addr_ok_i(dec_ok), .bank_i(dec_bank), .array_i(dec_arr), .tap_i(dec_tap),
        .wdata_i(host_wdata_i), .rdata_o(store_rd), .flat_o(coef_bank_o)
    );

    coef_active_sel #(
        .NUM_ARRAYS(NUM_ARRAYS), .NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W)
    ) sel_i (
        .flat_i(coef_bank_o), .bank_i(act_bank), .unsigned_i(unsigned_mode_i),
        .act_o(act_coef_o)
    );

    // Read data is taken from the stored copy before any same-edge write.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (host_rd_i) rdata_q <= dec_ok ? store_rd : '0;
    end

    // Sticky flag: host wrote a bank the arrays are using.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (host_wr_i && dec_ok && dec_bank == act_bank) err_q <= 1'b1;
    end

    assign host_rdata_o  = rdata_q;
    assign active_bank_o = act_bank;
    assign wr_err_o      = err_q;
endmodule

// File: rtl/coef_regfile_chk.sv
module coef_regfile_chk #(
    parameter int ADDR_W      = 9,
    parameter int COEF_W      = 8,
    parameter int BANK_STRIDE = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr_i,
    input logic              host_wr_i,
    input logic              host_rd_i,
    input logic [COEF_W-1:0] host_rdata_o,
    input logic              bank_sel_i,
    input logic              swap_mode_i,
    input logic              swap_strobe_i,
    input logic              active_bank_o,
    input logic              wr_err_o
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(2 * BANK_STRIDE);

    p_undef_rd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && host_addr_i >= TOP_ADDR) |=> (host_rdata_o == '0));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |=> wr_err_o);

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_err_o) |-> $past(host_wr_i));

    p_fixed_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_mode_i |=> (active_bank_o == $past(bank_sel_i)));

    p_swap_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(swap_mode_i) && swap_mode_i && swap_strobe_i)
        |=> (active_bank_o != $past(active_bank_o)));

    p_swap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(swap_mode_i) && swap_mode_i && !swap_strobe_i)
        |=> $stable(active_bank_o));

    p_swap_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(swap_mode_i) && swap_mode_i) |=> $stable(active_bank_o));
endmodule

bind coef_regfile coef_regfile_chk #(
    .ADDR_W(ADDR_W), .COEF_W(COEF_W), .BANK_STRIDE(BANK_STRIDE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .host_addr_i(host_addr_i), .host_wr_i(host_wr_i),
    .host_rd_i(host_rd_i), .host_rdata_o(host_rdata_o), .bank_sel_i(bank_sel_i),
    .swap_mode_i(swap_mode_i), .swap_strobe_i(swap_strobe_i),
    .active_bank_o(active_bank_o), .wr_err_o(wr_err_o)
);

// File: tb/coef_regfile_tb.sv
module coef_regfile_tb_top;
    localparam int NA = 3, NT = 7, W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [8:0] addr = '0;
    logic wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic bsel = 1'b0, smode = 1'b0, strb = 1'b0, umode = 1'b0;
    logic [2*NA*NT*W-1:0] coef_bank;
    logic [NA*NT*(W+1)-1:0] act_coef;
    logic act_bank, wr_err;

    int vectors = 0, fails = 0;

    logic [7:0] m_mem [2][NA][NT];
    logic       m_bank, m_alt, m_err;
    logic [7:0] m_rdata;

    always #5 clk = ~clk;

    coef_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr_i(addr), .host_wr_i(wr), .host_rd_i(rd),
        .host_wdata_i(wdata), .host_rdata_o(rdata), .bank_sel_i(bsel),
        .swap_mode_i(smode), .swap_strobe_i(strb), .unsigned_mode_i(umode),
        .coef_bank_o(coef_bank), .act_coef_o(act_coef), .active_bank_o(act_bank),
        .wr_err_o(wr_err)
    );

    function automatic bit addr_ok(input logic [8:0] a);
        return (a < 9'h080) && (a[5:4] != 2'd3) && (a[3:0] < 4'd7);
    endfunction

    function automatic int arr_of(input logic [8:0] a);
        return 2 - int'(a[5:4]);
    endfunction

    function automatic logic [8:0] widen(input logic [7:0] c, input logic u);
        return u ? {1'b0, c} : {c[7], c};
    endfunction

    function automatic logic [8:0] pick_addr();
        if ($urandom_range(0, 9) < 7)
            return {2'b00, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 2)),
                    4'($urandom_range(0, 6))};
        return 9'($urandom);
    endfunction

    task automatic check(input bit ok, input string req, input logic [511:0] act,
                         input logic [511:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < NA; a++)
                for (int t = 0; t < NT; t++) m_mem[b][a][t] = '0;
        m_bank = 0; m_alt = 0; m_err = 0; m_rdata = '0;
    endtask

    task automatic check_all(input bit did_rd);
        logic [2*NA*NT*W-1:0] eb;
        logic [NA*NT*(W+1)-1:0] ea;
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < NA; a++)
                for (int t = 0; t < NT; t++)
                    eb[((b*NA+a)*NT+t)*W +: W] = m_mem[b][a][t];
        for (int a = 0; a < NA; a++)
            for (int t = 0; t < NT; t++)
                ea[(a*NT+t)*(W+1) +: W+1] = widen(m_mem[m_bank][a][t], umode);
        check(coef_bank == eb, "R2/R5 coef_bank_o", 512'(coef_bank), 512'(eb));
        check(act_coef == ea, "R9 act_coef_o", 512'(act_coef), 512'(ea));
        check(act_bank == m_bank, "R6/R7/R8 active_bank_o", 512'(act_bank), 512'(m_bank));
        check(wr_err == m_err, "R10 wr_err_o", 512'(wr_err), 512'(m_err));
        if (did_rd) check(rdata == m_rdata, "R3/R4 host_rdata_o", 512'(rdata), 512'(m_rdata));
    endtask

    // One clock: drive at the falling edge, update the model, compare at the next falling edge.
    task automatic step(input logic w, input logic r, input logic [8:0] a, input logic [7:0] d,
                        input logic bs, input logic sm, input logic st, input logic um);
        wr = w; rd = r; addr = a; wdata = d; bsel = bs; smode = sm; strb = st; umode = um;
        @(posedge clk);
        if (r) m_rdata = addr_ok(a) ? m_mem[a[6]][arr_of(a)][a[3:0]] : 8'h00;
        if (w && addr_ok(a)) begin
            if (a[6] == m_bank) m_err = 1;
            m_mem[a[6]][arr_of(a)][a[3:0]] = d;
        end
        if (!sm) begin m_alt = 0; m_bank = bs; end
        else if (!m_alt) m_alt = 1;
        else if (st) m_bank = ~m_bank;
        @(negedge clk);
        check_all(r);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00c0ef11));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(coef_bank == '0, "R1 coefficients", 512'(coef_bank), 512'(0));
        check(act_bank == 1'b0, "R1 active bank", 512'(act_bank), 512'(0));
        check(wr_err == 1'b0, "R1 error flag", 512'(wr_err), 512'(0));
        check(rdata == 8'h00, "R1 read data", 512'(rdata), 512'(0));

        // R2/R10: fill bank 1 while bank 0 is active, flag stays low
        step(1, 0, 9'h040, 8'h81, 0, 0, 0, 0);
        step(1, 0, 9'h046, 8'h7f, 0, 0, 0, 0);
        step(1, 0, 9'h066, 8'hc3, 0, 0, 0, 1);
        step(1, 0, 9'h050, 8'h12, 0, 0, 0, 1);
        // R3 readback, including read and write of one address in one cycle
        step(0, 1, 9'h046, 8'h00, 0, 0, 0, 0);
        step(1, 1, 9'h066, 8'h55, 0, 0, 0, 0);
        step(0, 1, 9'h066, 8'h00, 0, 0, 0, 0);
        // R5 undefined writes, then R4 undefined reads
        step(1, 0, 9'h047, 8'hee, 0, 0, 0, 0);
        step(1, 0, 9'h070, 8'hee, 0, 0, 0, 0);
        step(1, 0, 9'h1ff, 8'hee, 0, 0, 0, 0);
        step(0, 1, 9'h047, 8'h00, 0, 0, 0, 0);
        step(0, 1, 9'h1ff, 8'h00, 0, 0, 0, 0);
        // R6: select bank 1; strobe without swap mode has no effect (R7)
        step(0, 0, 9'h000, 8'h00, 1, 0, 1, 0);
        step(0, 0, 9'h000, 8'h00, 1, 0, 1, 1);
        // R7: entry keeps bank 1, strobes toggle, gaps hold
        step(0, 0, 9'h000, 8'h00, 1, 1, 1, 0);
        step(0, 0, 9'h000, 8'h00, 1, 1, 1, 0);
        step(0, 0, 9'h000, 8'h00, 0, 1, 0, 0);
        step(0, 0, 9'h000, 8'h00, 0, 1, 1, 0);
        // R8: exit follows select
        step(0, 0, 9'h000, 8'h00, 0, 0, 0, 0);
        // R10: write to active bank 0 is stored and sets the flag
        step(1, 0, 9'h022, 8'h9a, 0, 0, 0, 0);
        step(0, 1, 9'h022, 8'h00, 0, 0, 0, 0);

        // Random phase
        begin
            logic bs_r = 0, sm_r = 0, um_r = 0;
            for (int i = 0; i < 3000; i++) begin
                if ($urandom_range(0, 7) == 0)  bs_r = ~bs_r;
                if ($urandom_range(0, 31) == 0) sm_r = ~sm_r;
                if ($urandom_range(0, 15) == 0) um_r = ~um_r;
                step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), pick_addr(),
                     8'($urandom), bs_r, sm_r, 1'($urandom_range(0, 3) == 0), um_r);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule